// File: doc/BRIEF.md
# Neural weight bank refresh sequencer

This block pages a complete synaptic weight matrix out of an external digital memory and into a 33-row by 32-column analog synapse array. The array is loaded through 32 parallel 8-bit D/A converters, one per column. A supervising finite-state controller picks which stored matrix (a bank) is wanted. On every n-th start of the pulse-modulation clock cycle the sequencer latches that bank. It then writes the bank one row at a time: it reads one memory word per row and strobes the 32 lanes together with the matching row select.

Writes happen only while the modulation cycle is in its idle phase. When the idle phase ends part way through a matrix, the sequencer stops and carries on from the next unwritten row in a later idle phase. Between two strobes it waits a programmable number of clock cycles, so that each converter finishes its conversion before it is strobed again. Because the bank is latched for a whole matrix, several virtual networks can share one physical array without one matrix ever being built from two banks.

Top module: `wbank_refresh_seq`

## Requirements
- R1: The row read from memory is addressed as bank*33 + row, and a read issued with `mem_rd_en` returns its data on the next cycle. That word is driven on `dac_data` (lane c in bits 8c+7..8c) in the same cycle as `dac_strobe`, with `row_sel` giving the row.
- R2: A refresh strobes rows 0 through 32 once each and in increasing order. `refresh_done` is high for one cycle, together with the strobe of row 32 and never otherwise.
- R3: `dac_strobe` is high only in a cycle whose preceding cycle had `mod_idle` high.
- R4: Two consecutive strobes are at least S+1 clock cycles apart, where S is `settle_cycles`. A value of 0 selects 10.
- R5: A refresh starts on every n-th pulse of `mod_cycle_start` counted since reset, where n is `every_n`. A value of 0 acts as 1.
- R6: The bank is sampled from `fsm_bank` when a refresh starts. Later changes to `fsm_bank` do not affect that refresh's data and are used by the next refresh.
- R7: When `mod_idle` falls during a refresh, no strobe is issued until it rises again. The refresh then resumes at the next unwritten row, with no row repeated or skipped.
- R8: Synchronous active-high `rst` clears the sequencer: no strobe, no done, no memory read, `row_sel` = 0, and the cycle count cleared.
- R9: A `mod_cycle_start` that falls due while a refresh is in progress is ignored. The running refresh is not restarted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| fsm_bank | input | 2 | Bank index requested by the supervising controller |
| mod_cycle_start | input | 1 | One-cycle pulse at the start of each modulation cycle |
| mod_idle | input | 1 | High during the idle phase of the modulation cycle |
| every_n | input | 8 | Refresh on every n-th modulation cycle (0 acts as 1) |
| settle_cycles | input | 8 | Minimum clocks between converter strobes (0 selects 10) |
| mem_rd_en | output | 1 | Weight memory read request |
| mem_addr | output | 8 | Weight memory word address |
| mem_rd_data | input | 256 | Memory word returned one cycle after the read |
| dac_data | output | 256 | 32 lanes of 8-bit weights for the converters |
| dac_strobe | output | 1 | Load strobe for all 32 converters |
| row_sel | output | 6 | Synapse row that receives the strobed weights |
| refresh_done | output | 1 | Pulse marking that the last row has been written |

## Verification
The assertions check four things on every cycle: a strobe is never issued outside the idle phase, the strobe spacing never drops below the settle count, the latched bank stays fixed for a whole refresh, and the done pulse only comes with the last row. Only the bench's scenarios can show the rest. These are that the data written for each row is the correct word for the bank and row, that rows carry on without a gap after a pause, and that the every-n-th cycle count gives the right number of refreshes. They also cover whether a bank change or an early trigger in the middle of a refresh is really ignored.

// File: rtl/wbr_pkg.sv
package wbr_pkg;

    localparam int ROWS_DEF   = 33;
    localparam int COLS_DEF   = 32;
    localparam int WW_DEF     = 8;
    localparam int NBANK_DEF  = 4;
    localparam int NW_DEF     = 8;
    localparam int SW_DEF     = 8;
    localparam int SETTLE_DEF = 10;

    typedef enum logic [1:0] {
        SQ_IDLE = 2'd0,
        SQ_WAIT = 2'd1,
        SQ_LOAD = 2'd2
    } seq_state_e;

    function automatic int unsigned row_addr(input int unsigned bank,
                                             input int unsigned row,
                                             input int unsigned rows);
        return bank * rows + row;
    endfunction

endpackage

// File: rtl/wbr_trigger.sv
module wbr_trigger #(
    parameter int NW = wbr_pkg::NW_DEF
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          cyc_start,
    input  logic [NW-1:0] every_n,
    output logic          fire
);
    logic [NW-1:0] cnt_q;
    logic [NW-1:0] n_eff;
    logic [NW:0]   cnt_next;
    logic          hit;

    assign n_eff    = (every_n == '0) ? NW'(1) : every_n;
    assign cnt_next = {1'b0, cnt_q} + (NW+1)'(1);
    assign hit      = cnt_next >= {1'b0, n_eff};
    assign fire     = cyc_start && hit;

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q <= '0;
        end else if (cyc_start) begin
            cnt_q <= hit ? '0 : cnt_next[NW-1:0];
        end
    end
endmodule

// File: rtl/wbr_pacer.sv
module wbr_pacer #(
    parameter int SW     = wbr_pkg::SW_DEF,
    parameter int SETTLE = wbr_pkg::SETTLE_DEF
) (
    input  logic          clk,
    input  logic          rst,
    input  logic [SW-1:0] settle_cycles,
    input  logic          load_fire,
    output logic          ready
);
    logic [SW-1:0] eff;
    logic [SW-1:0] wait_q;
    logic [SW:0]   since_q;

    assign eff   = (settle_cycles == '0) ? SW'(SETTLE) : settle_cycles;
    assign ready = (wait_q == '0);

    always_ff @(posedge clk) begin
        if (rst) begin
            wait_q <= '0;
        end else if (load_fire) begin
            wait_q <= eff;
        end else if (wait_q != '0) begin
            wait_q <= wait_q - SW'(1);
        end
    end

    // cycles since the last converter load, saturating
    always_ff @(posedge clk) begin
        if (rst) begin
            since_q <= '1;
        end else if (load_fire) begin
            since_q <= '0;
        end else if (since_q != '1) begin
            since_q <= since_q + (SW+1)'(1);
        end
    end

    // R4
    settle_gap_chk: assert property (@(posedge clk) disable iff (rst)
        load_fire |-> (since_q > {1'b0, eff}));
endmodule

// File: rtl/wbr_core.sv
module wbr_core
    import wbr_pkg::*;
#(
    parameter int ROWS  = ROWS_DEF,
    parameter int COLS  = COLS_DEF,
    parameter int WW    = WW_DEF,
    parameter int NBANK = NBANK_DEF
) (
    input  logic                         clk,
    input  logic                         rst,
    input  logic                         start,
    input  logic [$clog2(NBANK)-1:0]     bank_in,
    input  logic                         mod_idle,
    input  logic                         ready,
    output logic                         load_fire,
    output logic                         mem_rd_en,
    output logic [$clog2(NBANK*ROWS)-1:0] mem_addr,
    input  logic [COLS*WW-1:0]           mem_rd_data,
    output logic [COLS*WW-1:0]           dac_data,
    output logic                         dac_strobe,
    output logic [$clog2(ROWS)-1:0]      row_sel,
    output logic                         refresh_done
);
    localparam int BW = $clog2(NBANK);
    localparam int AW = $clog2(NBANK*ROWS);
    localparam int RW = $clog2(ROWS);
    localparam logic [RW-1:0] LAST_ROW = RW'(ROWS-1);

    seq_state_e    state_q;
    logic [RW-1:0] row_q;
    logic [BW-1:0] bank_q;

    assign mem_rd_en = (state_q == SQ_WAIT) && ready && mod_idle;
    assign mem_addr  = AW'(row_addr(32'(bank_q), 32'(row_q), ROWS));
    assign load_fire = (state_q == SQ_LOAD) && mod_idle;

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q      <= SQ_IDLE;
            row_q        <= '0;
            bank_q       <= '0;
            dac_data     <= '0;
            dac_strobe   <= 1'b0;
            row_sel      <= '0;
            refresh_done <= 1'b0;
        end else begin
            dac_strobe   <= 1'b0;
            refresh_done <= 1'b0;
            case (state_q)
                SQ_IDLE: begin
                    if (start) begin
                        bank_q  <= bank_in;
                        row_q   <= '0;
                        state_q <= SQ_WAIT;
                    end
                end
                SQ_WAIT: begin
                    if (mem_rd_en) state_q <= SQ_LOAD;
                end
                SQ_LOAD: begin
                    if (mod_idle) begin
                        dac_data   <= mem_rd_data;
                        dac_strobe <= 1'b1;
                        row_sel    <= row_q;
                        if (row_q == LAST_ROW) begin
                            refresh_done <= 1'b1;
                            row_q        <= '0;
                            state_q      <= SQ_IDLE;
                        end else begin
                            row_q   <= row_q + RW'(1);
                            state_q <= SQ_WAIT;
                        end
                    end else begin
                        // idle phase closed: drop this read, retry the row later
                        state_q <= SQ_WAIT;
                    end
                end
                default: state_q <= SQ_IDLE;
            endcase
        end
    end

    // R3
    strobe_idle_chk: assert property (@(posedge clk) disable iff (rst)
        dac_strobe |-> $past(mod_idle));

    // R2
    done_row_chk: assert property (@(posedge clk) disable iff (rst)
        refresh_done |-> (dac_strobe && row_sel == LAST_ROW));

    // R6
    bank_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (state_q != SQ_IDLE && $past(state_q) != SQ_IDLE) |-> $stable(bank_q));

    // R1
    row_range_chk: assert property (@(posedge clk) disable iff (rst)
        mem_rd_en |-> (row_q <= LAST_ROW));
endmodule

// File: rtl/wbank_refresh_seq.sv
module wbank_refresh_seq
    import wbr_pkg::*;
#(
    parameter int ROWS   = ROWS_DEF,
    parameter int COLS   = COLS_DEF,
    parameter int WW     = WW_DEF,
    parameter int NBANK  = NBANK_DEF,
    parameter int NW     = NW_DEF,
    parameter int SW     = SW_DEF,
    parameter int SETTLE = SETTLE_DEF
) (
    input  logic                          clk,
    input  logic                          rst,
    input  logic [$clog2(NBANK)-1:0]      fsm_bank,
    input  logic                          mod_cycle_start,
    input  logic                          mod_idle,
    input  logic [NW-1:0]                 every_n,
    input  logic [SW-1:0]                 settle_cycles,
    output logic                          mem_rd_en,
    output logic [$clog2(NBANK*ROWS)-1:0] mem_addr,
    input  logic [COLS*WW-1:0]            mem_rd_data,
    output logic [COLS*WW-1:0]            dac_data,
    output logic                          dac_strobe,
    output logic [$clog2(ROWS)-1:0]       row_sel,
    output logic                          refresh_done
);
    logic start;
    logic ready;
    logic load_fire;

    wbr_trigger #(.NW(NW)) u_trig (
        .clk       (clk),
        .rst       (rst),
        .cyc_start (mod_cycle_start),
        .every_n   (every_n),
        .fire      (start)
    );

    wbr_pacer #(.SW(SW), .SETTLE(SETTLE)) u_pace (
        .clk           (clk),
        .rst           (rst),
        .settle_cycles (settle_cycles),
        .load_fire     (load_fire),
        .ready         (ready)
    );

    wbr_core #(.ROWS(ROWS), .COLS(COLS), .WW(WW), .NBANK(NBANK)) u_core (
        .clk          (clk),
        .rst          (rst),
        .start        (start),
        .bank_in      (fsm_bank),
        .mod_idle     (mod_idle),
        .ready        (ready),
        .load_fire    (load_fire),
        .mem_rd_en    (mem_rd_en),
        .mem_addr     (mem_addr),
        .mem_rd_data  (mem_rd_data),
        .dac_data     (dac_data),
        .dac_strobe   (dac_strobe),
        .row_sel      (row_sel),
        .refresh_done (refresh_done)
    );
endmodule

// File: tb/sim_wbank_refresh_seq.sv
`timescale 1ns/1ps
module sim_wbank_refresh_seq;
    localparam int ROWS = 33, COLS = 32, WW = 8;

    logic         clk = 1'b0;
    logic         rst = 1'b1;
    logic [1:0]   fsm_bank = '0;
    logic         mod_cycle_start = 1'b0;
    logic         mod_idle = 1'b0;
    logic [7:0]   every_n = 8'd1;
    logic [7:0]   settle_cycles = 8'd0;
    logic         mem_rd_en;
    logic [7:0]   mem_addr;
    logic [COLS*WW-1:0] mem_rd_data = '0;
    logic [COLS*WW-1:0] dac_data;
    logic         dac_strobe;
    logic [5:0]   row_sel;
    logic         refresh_done;

    int checks = 0;
    int errors = 0;
    int done_cnt = 0;
    int strobe_cnt = 0;
    int exp_row = 0;
    int exp_bank = 0;
    longint cyc = 0;
    longint last_strobe = -1000;
    bit idle_prev = 1'b0;

    always #2 clk = ~clk;

    wbank_refresh_seq u0 (
        .clk(clk), .rst(rst), .fsm_bank(fsm_bank),
        .mod_cycle_start(mod_cycle_start), .mod_idle(mod_idle),
        .every_n(every_n), .settle_cycles(settle_cycles),
        .mem_rd_en(mem_rd_en), .mem_addr(mem_addr), .mem_rd_data(mem_rd_data),
        .dac_data(dac_data), .dac_strobe(dac_strobe), .row_sel(row_sel),
        .refresh_done(refresh_done)
    );

    function automatic logic [COLS*WW-1:0] pattern(input int addr);
        logic [COLS*WW-1:0] w;
        for (int c = 0; c < COLS; c++) w[c*WW +: WW] = 8'((addr * 7 + c * 29 + 3) & 255);
        return w;
    endfunction

    function automatic int settle_eff(input logic [7:0] s);
        return (s == 0) ? 10 : int'(s);
    endfunction

    // synchronous memory model, one cycle read latency
    always @(posedge clk) if (mem_rd_en) mem_rd_data <= pattern(int'(mem_addr));

    task automatic chk(input bit ok, input string req, input longint act, input longint exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // output monitor, sampled away from the active edge
    always @(negedge clk) begin
        cyc++;
        if (rst) begin
            exp_row = 0;
        end else begin
            if (dac_strobe) begin
                strobe_cnt++;
                chk(idle_prev, "R3 strobe outside idle phase", 0, 1);
                chk(int'(row_sel) == exp_row, "R2/R7 row order", row_sel, exp_row);
                chk(dac_data == pattern(exp_bank * ROWS + exp_row), "R1/R6 row data",
                    dac_data[31:0], pattern(exp_bank * ROWS + exp_row) >> 0 & 32'hFFFFFFFF);
                chk(cyc - last_strobe >= settle_eff(settle_cycles) + 1, "R4 strobe spacing",
                    cyc - last_strobe, settle_eff(settle_cycles) + 1);
                last_strobe = cyc;
                if (refresh_done) begin
                    chk(exp_row == ROWS - 1, "R2 done row", exp_row, ROWS - 1);
                    done_cnt++;
                    exp_row = 0;
                end else begin
                    exp_row++;
                end
            end else if (refresh_done) begin
                chk(1'b0, "R2 done without strobe", 1, 0);
            end
        end
        idle_prev = mod_idle;
    end

    task automatic tick();
        @(posedge clk);
        #1;
    endtask

    task automatic mod_cycle(input int idle_len, input int busy_len);
        mod_cycle_start = 1'b1;
        mod_idle = 1'b1;
        tick();
        mod_cycle_start = 1'b0;
        repeat (idle_len - 1) tick();
        mod_idle = 1'b0;
        repeat (busy_len) tick();
    endtask

    task automatic do_reset();
        rst = 1'b1;
        mod_idle = 1'b0;
        mod_cycle_start = 1'b0;
        repeat (3) tick();
        rst = 1'b0;
        tick();
    endtask

    task automatic summary();
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog expired actual=%0d expected=%0d", 0, 1);
        summary();
    end

    initial begin
        int d0;
        int s0;
        int guard;
        void'($urandom(32'h5EED_0417));

        // R8 reset state
        do_reset();
        @(negedge clk);
        chk(dac_strobe == 0, "R8 strobe after reset", dac_strobe, 0);
        chk(refresh_done == 0, "R8 done after reset", refresh_done, 0);
        chk(row_sel == 0, "R8 row_sel after reset", row_sel, 0);
        chk(mem_rd_en == 0, "R8 read after reset", mem_rd_en, 0);
        tick();

        // R1 R2 R4: full refresh, every cycle, default settle
        every_n = 8'd1; settle_cycles = 8'd0; fsm_bank = 2'd1; exp_bank = 1;
        d0 = done_cnt; s0 = strobe_cnt;
        mod_cycle(460, 20);
        chk(done_cnt == d0 + 1, "R2 one refresh per cycle", done_cnt - d0, 1);
        chk(strobe_cnt == s0 + ROWS, "R2 strobes per refresh", strobe_cnt - s0, ROWS);

        // R5: every third cycle, then n=0 acts as 1
        do_reset();
        every_n = 8'd3; settle_cycles = 8'd4; fsm_bank = 2'd2; exp_bank = 2;
        d0 = done_cnt;
        for (int k = 1; k <= 6; k++) begin
            mod_cycle(250, 10);
            if (k == 2) chk(done_cnt == d0, "R5 no refresh before third cycle", done_cnt - d0, 0);
            if (k == 3) chk(done_cnt == d0 + 1, "R5 refresh on third cycle", done_cnt - d0, 1);
        end
        chk(done_cnt == d0 + 2, "R5 refreshes in six cycles n=3", done_cnt - d0, 2);
        every_n = 8'd0;
        d0 = done_cnt;
        mod_cycle(250, 10);
        mod_cycle(250, 10);
        chk(done_cnt == d0 + 2, "R5 n=0 acts as every cycle", done_cnt - d0, 2);

        // R7: short idle windows force pauses and resumes
        every_n = 8'd1; settle_cycles = 8'd2; fsm_bank = 2'd3; exp_bank = 3;
        d0 = done_cnt; s0 = strobe_cnt;
        mod_cycle(40, 30);
        chk(strobe_cnt - s0 < ROWS && strobe_cnt - s0 > 0, "R7 partial rows in first window",
            strobe_cnt - s0, 8);
        guard = 0;
        while (done_cnt == d0 && guard < 50) begin mod_cycle(40, 30); guard++; end
        chk(done_cnt == d0 + 1, "R7 refresh completes across pauses", done_cnt - d0, 1);

        // R6: bank change mid refresh is ignored until the next refresh
        settle_cycles = 8'd5; fsm_bank = 2'd0; exp_bank = 0;
        d0 = done_cnt;
        mod_cycle_start = 1'b1; mod_idle = 1'b1; tick(); mod_cycle_start = 1'b0;
        repeat (60) tick();
        fsm_bank = 2'd2;
        repeat (300) tick();
        mod_idle = 1'b0; repeat (10) tick();
        chk(done_cnt == d0 + 1, "R6 refresh with old bank done", done_cnt - d0, 1);
        exp_bank = 2;
        mod_cycle(300, 10);
        chk(done_cnt == d0 + 2, "R6 next refresh uses new bank", done_cnt - d0, 2);

        // R9: a second cycle start during a refresh does not restart it
        fsm_bank = 2'd1; exp_bank = 1;
        d0 = done_cnt; s0 = strobe_cnt;
        mod_cycle(50, 5);
        fsm_bank = 2'd3;
        mod_cycle(300, 5);
        chk(done_cnt == d0 + 1, "R9 early trigger ignored", done_cnt - d0, 1);
        chk(strobe_cnt == s0 + ROWS, "R9 no restarted rows", strobe_cnt - s0, ROWS);

        // random mix of banks, settle counts and phase lengths
        for (int it = 0; it < 6; it++) begin
            int b;
            b = int'($urandom_range(0, 3));
            fsm_bank = 2'(b); exp_bank = b;
            settle_cycles = 8'($urandom_range(1, 15));
            d0 = done_cnt;
            guard = 0;
            while (done_cnt == d0 && guard < 80) begin
                mod_cycle(int'($urandom_range(20, 90)), int'($urandom_range(5, 40)));
                guard++;
            end
            chk(done_cnt == d0 + 1, "R1 random refresh completes", done_cnt - d0, 1);
        end

        repeat (5) tick();
        summary();
    end
endmodule